// File: doc/BRIEF.md
# Floating-Point Execution Pipe with Variable Divide Occupancy

This block models the timing of a floating-point execution pipe. The pipe has one dispatch slot, six execute stages and one writeback stage. It accepts one operation per cycle from an issue source. An operation can be general arithmetic, fused multiply-add, compare, single divide, double divide or load. Each operation names a destination register and up to three source registers.

The dispatch slot holds an operation until its sources are forwardable. Readiness comes from a small countdown per register, loaded when the producer leaves dispatch. A compare does not write a data register: it updates a single condition flag, which later operations may ask to wait on.

Divides are the exception to forwarding. Their results are never forwarded. A divide also sits in writeback for many cycles, and while it does, everything upstream of writeback freezes. The arithmetic itself is not modelled. Only timing, occupancy and hazards are.

Top module: `fpu_pipe`

## Requirements
- R1: After reset `in_ready` is 1, and `go`, `stall`, `wb_valid` and `wb_retire` are all 0.
- R2: Operation codes on `in_op` are: 0 general, 1 fused multiply-add, 2 compare, 3 single divide, 4 double divide, 5 load; 6 and 7 act as general. An operation leaves dispatch (`go` high) in some cycle T. If there is no stall, it is in writeback with its `wb_dst` and `wb_op` in cycle T+7. Independent operations leave dispatch in consecutive cycles.
- R3: After a general, fused multiply-add or code-6 producer leaves dispatch in cycle T, a reader of its destination leaves dispatch no earlier than T+5, and at T+5 when nothing else blocks it.
- R4: Source use depends on the operation. Fused multiply-add checks all three sources. General, compare and both divides check sources a and b only. A load checks none. An unchecked source never delays dispatch.
- R5: A load's destination becomes forwardable 4 cycles after the load leaves dispatch.
- R6: A compare writes only the condition flag, and its `in_dst` field is ignored. An operation with `in_usecond`=1 leaves dispatch no earlier than 2 cycles after the compare does. A reader of the compare's `in_dst` register is not delayed.
- R7: A double divide holds writeback for 25 cycles and a single divide for 13. Every other operation holds it for 1 cycle. `wb_retire` is high only in the last writeback cycle, and `wb_op`/`wb_dst` stay steady until then.
- R8: While a divide is in writeback and not in its last cycle, `stall` is 1. During that time the execute stages hold, no operation leaves dispatch, and an independent operation behind the divide reaches writeback only after the divide retires.
- R9: A divide result is not forwarded. Two kinds of operation wait until the cycle after the divide's `wb_retire`: one that reads the divide's destination, and one that writes it.
- R10: `in_ready` is 1 exactly when dispatch is empty or emptying this cycle. An operation is taken only when `in_valid` and `in_ready` are both high. Each taken operation leaves dispatch exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_op | input | 3 | Operation code |
| in_dst | input | 5 | Destination register |
| in_sa | input | 5 | Source register a |
| in_sb | input | 5 | Source register b |
| in_sc | input | 5 | Source register c (fused multiply-add only) |
| in_usecond | input | 1 | Operation waits on the condition flag |
| in_ready | output | 1 | Dispatch can take an operation this cycle |
| go | output | 1 | Operation in dispatch moves to the first execute stage |
| stall | output | 1 | Divide holding writeback; upstream frozen |
| wb_valid | output | 1 | Writeback stage occupied |
| wb_retire | output | 1 | Last writeback cycle of the occupant |
| wb_op | output | 3 | Operation code in writeback |
| wb_dst | output | 5 | Destination register in writeback |

## Verification
Every result is timed from the cycle its producer pulses `go`. The earliest dependent `go` is due 5 cycles later for arithmetic, 4 for a load and 2 for a condition reader. For a divide it is 7 plus the occupancy (20 or 32). The retire is due 7 cycles after `go`, or 6 plus the occupancy for a divide. An independent operation behind a divide retires 7 plus the occupancy after the divide's `go`. The bench timestamps each `go` and `wb_retire` from a free-running cycle count, sampled on the falling edge. It then compares differences of those stamps with the figures above, so a check never depends on when it happens to look.

// File: rtl/fpu_pipe.sv
module fpu_pipe #(
  parameter int NREG      = 32,
  parameter int NEX       = 6,
  parameter int LAT_ARITH = 5,
  parameter int LAT_LOAD  = 4,
  parameter int LAT_COND  = 2,
  parameter int OCC_DIVS  = 13,
  parameter int OCC_DIVD  = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_op,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_sa,
  input  logic [$clog2(NREG)-1:0] in_sb,
  input  logic [$clog2(NREG)-1:0] in_sc,
  input  logic                    in_usecond,
  output logic                    in_ready,
  output logic                    go,
  output logic                    stall,
  output logic                    wb_valid,
  output logic                    wb_retire,
  output logic [2:0]              wb_op,
  output logic [$clog2(NREG)-1:0] wb_dst
);
  localparam int RW   = $clog2(NREG);
  localparam int MAXL = (LAT_ARITH > LAT_LOAD) ? ((LAT_ARITH > LAT_COND) ? LAT_ARITH : LAT_COND)
                                               : ((LAT_LOAD > LAT_COND) ? LAT_LOAD : LAT_COND);
  localparam int CW   = $clog2(MAXL + 1);
  localparam int OW   = $clog2(OCC_DIVD + 1);

  localparam logic [2:0] OP_FMA  = 3'd1;
  localparam logic [2:0] OP_CMP  = 3'd2;
  localparam logic [2:0] OP_DIVS = 3'd3;
  localparam logic [2:0] OP_DIVD = 3'd4;
  localparam logic [2:0] OP_LOAD = 3'd5;

  typedef struct packed {
    logic          v;
    logic [2:0]    op;
    logic [RW-1:0] dst;
  } slot_t;

  logic          d_v, d_uc;
  logic [2:0]    d_op;
  logic [RW-1:0] d_dst, d_sa, d_sb, d_sc;

  slot_t [NEX-1:0] ex;
  slot_t           wbs;
  logic [OW-1:0]   wb_left;

  logic [CW-1:0]   cnt [NREG];
  logic [NREG-1:0] pend;
  logic [NREG-1:0] busy;
  logic [CW-1:0]   ccnt;

  logic use_ab, use_c, wr_dst, d_div, wb_div, hazard;
  logic [CW-1:0] lat_sel;

  assign use_ab  = d_op != OP_LOAD;
  assign use_c   = d_op == OP_FMA;
  assign wr_dst  = d_op != OP_CMP;
  assign d_div   = (d_op == OP_DIVS) || (d_op == OP_DIVD);
  assign wb_div  = (wbs.op == OP_DIVS) || (wbs.op == OP_DIVD);
  assign lat_sel = (d_op == OP_LOAD) ? CW'(LAT_LOAD - 1) : CW'(LAT_ARITH - 1);

  always_comb
    for (int r = 0; r < NREG; r++) busy[r] = pend[r] || (cnt[r] != '0);

  assign hazard = (use_ab && (busy[d_sa] || busy[d_sb]))
               || (use_c && busy[d_sc])
               || (wr_dst && pend[d_dst])
               || (d_uc && (ccnt != '0));

  assign stall     = wbs.v && (wb_left != '0);
  assign go        = d_v && !stall && !hazard;
  assign in_ready  = !d_v || go;
  assign wb_valid  = wbs.v;
  assign wb_retire = wbs.v && (wb_left == '0);
  assign wb_op     = wbs.op;
  assign wb_dst    = wbs.dst;

  function automatic logic [OW-1:0] hold_of(slot_t s);
    if (!s.v)                 return '0;
    else if (s.op == OP_DIVD) return OW'(OCC_DIVD - 1);
    else if (s.op == OP_DIVS) return OW'(OCC_DIVS - 1);
    else                      return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v <= 1'b0; d_uc <= 1'b0; d_op <= '0;
      d_dst <= '0; d_sa <= '0; d_sb <= '0; d_sc <= '0;
    end else if (in_valid && in_ready) begin
      d_v <= 1'b1; d_uc <= in_usecond; d_op <= in_op;
      d_dst <= in_dst; d_sa <= in_sa; d_sb <= in_sb; d_sc <= in_sc;
    end else if (go) begin
      d_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex      <= '0;
      wbs     <= '0;
      wb_left <= '0;
    end else if (!stall) begin
      ex[0]   <= '{v: go, op: d_op, dst: d_dst};
      for (int i = 1; i < NEX; i++) ex[i] <= ex[i-1];
      wbs     <= ex[NEX-1];
      wb_left <= hold_of(ex[NEX-1]);
    end else begin
      wb_left <= wb_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ccnt <= '0;
      for (int r = 0; r < NREG; r++) cnt[r] <= '0;
    end else begin
      if (go && (d_op == OP_CMP))   ccnt <= CW'(LAT_COND - 1);
      else if (!stall && ccnt != '0) ccnt <= ccnt - 1'b1;
      for (int r = 0; r < NREG; r++) begin
        if (go && wr_dst && (d_dst == RW'(r))) begin
          pend[r] <= d_div;
          cnt[r]  <= d_div ? '0 : lat_sel;
        end else begin
          if (!stall && cnt[r] != '0) cnt[r] <= cnt[r] - 1'b1;
          if (wb_retire && wb_div && (wbs.dst == RW'(r))) pend[r] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fpu_pipe_chk.sv
module fpu_pipe_chk #(
  parameter int NEX      = 6,
  parameter int RW       = 5,
  parameter int OCC_DIVS = 13,
  parameter int OCC_DIVD = 25
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    go,
  input logic                    stall,
  input logic                    wb_valid,
  input logic                    wb_retire,
  input logic [2:0]              wb_op,
  input logic [RW-1:0]           wb_dst,
  input logic [NEX*(4+RW)-1:0]   ex_bits
);
  localparam int SW = 4 + RW;
  int seen;
  int exp_occ;

  always_comb
    exp_occ = (wb_op == 3'd4) ? OCC_DIVD : (wb_op == 3'd3) ? OCC_DIVS : 1;

  always_ff @(posedge clk) begin
    if (!rst_n)         seen <= 0;
    else if (wb_retire) seen <= 0;
    else if (wb_valid)  seen <= seen + 1;
  end

  // R7
  wb_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_retire |-> (seen + 1 == exp_occ));

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_retire) |=> (wb_valid && $stable(wb_op) && $stable(wb_dst)));

  // R8
  ex_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ex_bits));

  // R8
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!go && wb_valid && (wb_op == 3'd3 || wb_op == 3'd4)));

  // R2
  enter_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ex_bits[SW-1]);
endmodule

bind fpu_pipe fpu_pipe_chk #(.NEX(NEX), .RW(RW), .OCC_DIVS(OCC_DIVS), .OCC_DIVD(OCC_DIVD)) u_fpu_pipe_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .stall(stall), .wb_valid(wb_valid),
  .wb_retire(wb_retire), .wb_op(wb_op), .wb_dst(wb_dst), .ex_bits(ex)
);

// File: tb/test_fpu_pipe.sv
module test_fpu_pipe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       in_valid = 1'b0, in_usecond = 1'b0;
  logic [2:0] in_op = '0;
  logic [4:0] in_dst = '0, in_sa = '0, in_sb = '0, in_sc = '0;
  logic       in_ready, go, stall, wb_valid, wb_retire;
  logic [2:0] wb_op;
  logic [4:0] wb_dst;

  fpu_pipe i_fpu_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_sa(in_sa), .in_sb(in_sb), .in_sc(in_sc), .in_usecond(in_usecond),
    .in_ready(in_ready), .go(go), .stall(stall), .wb_valid(wb_valid),
    .wb_retire(wb_retire), .wb_op(wb_op), .wb_dst(wb_dst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int go_t [512];
  int rt_t [512];
  int rt_d [512];
  int rt_o [512];
  int n_go = 0, n_rt = 0, n_stall = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (go)        begin go_t[n_go] = cyc; n_go++; end
    if (wb_retire) begin rt_t[n_rt] = cyc; rt_d[n_rt] = wb_dst; rt_o[n_rt] = wb_op; n_rt++; end
    if (stall)     n_stall++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int op, int dst, int a, int b, int c, bit uc);
    in_valid = 1'b1; in_op = 3'(op); in_dst = 5'(dst);
    in_sa = 5'(a); in_sb = 5'(b); in_sc = 5'(c); in_usecond = uc;
    forever begin
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int occ(int p);
    return (p == 4) ? 25 : (p == 3) ? 13 : 1;
  endfunction

  function automatic int gap_of(int p);
    if (p == 4) return 32;
    if (p == 3) return 20;
    if (p == 5) return 4;
    return 5;
  endfunction

  function automatic bit uses(int c, int slot);
    return (slot < 2) ? (c != 5) : (c == 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int prods [6] = '{0, 1, 6, 5, 3, 4};
    int g0, r0, s0, pg, cg, eg, ecr;
    bit u, dv;
    string rq;

    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 go", int'(go), 0);
    chk("R1 stall", int'(stall), 0);
    chk("R1 wb_valid", int'(wb_valid), 0);
    chk("R1 wb_retire", int'(wb_retire), 0);

    foreach (prods[pi]) begin
      for (int c = 0; c < 3; c++) begin
        for (int slot = 0; slot < 3; slot++) begin
          int p;
          p = prods[pi];
          g0 = n_go; r0 = n_rt; s0 = n_stall;
          send(p, 5, 1, 2, 3, 1'b0);
          send(c, 8, (slot == 0) ? 5 : 1, (slot == 1) ? 5 : 2, (slot == 2) ? 5 : 3, 1'b0);
          repeat (50) @(negedge clk);
          u  = uses(c, slot);
          dv = (p == 3) || (p == 4);
          pg = go_t[g0]; cg = go_t[g0 + 1];
          eg = u ? gap_of(p) : 1;
          rq = dv ? "R9" : (p == 5) ? "R5" : "R3";
          if (!u) rq = "R4";
          chk($sformatf("%s dispatch gap p=%0d c=%0d s=%0d", rq, p, c, slot), cg - pg, eg);
          chk(dv ? "R7 producer retire" : "R2 producer retire", rt_t[r0] - pg, 6 + occ(p));
          chk("R2 producer wb_dst", rt_d[r0], 5);
          chk("R2 producer wb_op", rt_o[r0], p);
          ecr = (dv && !u) ? pg + 7 + occ(p) : cg + 7;
          chk(dv && !u ? "R8 retire behind divide" : "R2 consumer retire", rt_t[r0 + 1], ecr);
          chk("R8 stall cycles", n_stall - s0, occ(p) - 1);
          chk("R10 one go per op", n_go - g0, 2);
        end
      end
    end

    g0 = n_go;
    send(2, 9, 1, 2, 0, 1'b0);
    send(0, 10, 1, 2, 0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R6 condition wait", go_t[g0 + 1] - go_t[g0], 2);

    g0 = n_go;
    send(2, 9, 1, 2, 0, 1'b0);
    send(1, 10, 9, 9, 9, 1'b0);
    repeat (20) @(negedge clk);
    chk("R6 compare dst ignored", go_t[g0 + 1] - go_t[g0], 1);

    g0 = n_go;
    send(4, 7, 1, 2, 0, 1'b0);
    send(5, 7, 0, 0, 0, 1'b0);
    repeat (50) @(negedge clk);
    chk("R9 write after divide", go_t[g0 + 1] - go_t[g0], 32);

    g0 = n_go;
    send(3, 11, 1, 2, 0, 1'b0);
    send(0, 12, 11, 0, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 ready low while held", int'(in_ready), 0);
    send(0, 13, 1, 2, 0, 1'b0);
    repeat (50) @(negedge clk);
    chk("R10 go count", n_go - g0, 3);
    chk("R10 held op then next", go_t[g0 + 2] - go_t[g0 + 1], 1);
    chk("R9 single divide reader", go_t[g0 + 1] - go_t[g0], 20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule